// File: doc/BRIEF.md
# Watchdog Timer with Programmable Tick Resolution

This block is a bus-mapped watchdog timer. Software programs a reload count, a tick resolution and two enables through one control register. A tick is one base second divided by two to the power of the resolution. While the timer is enabled, its counter steps down once per tick. When it runs out, the block sets a sticky timeout flag and can also issue a one-cycle system reset request.

A control write is not applied at once. It opens a load phase that lasts a fixed number of clock cycles, and a readable busy bit stays set for that whole phase. At the end of the phase the reload count is copied into the running counter and the prescaler restarts from a clean phase. Software keeps the system alive by rewriting the control register, with enable set, before the count runs out. Clearing enable stops the countdown.

The register port takes single-cycle requests. A read returns its data, with a response strobe, one cycle after the request. Writes complete in the cycle they are presented. The port has no back-pressure.

Top module: `wdt_timer`

## Requirements
- R1: After reset, the control register reads 0x0040_0000 (resolution 4, count 0, both enables off), the count register reads 0, and timeout_o and rst_req_o are low.
- R2: A read request at offset 0x0 or 0x4 returns its register one cycle later with rsp_valid high. Any other offset reads as zero. Control bit fields are: 28 busy (read-only), 27 enable, 26 reset-on-expiry enable, 23:20 resolution, 19:0 reload count. Bits 31:29, 25 and 24 read as zero, whatever was written to them.
- R3: A control write accepted at clock edge E sets the busy bit for exactly LOAD_CYCLES cycles, starting after E. The busy bit clears at edge E+LOAD_CYCLES, and the reload count enters the counter at that same edge.
- R4: Any write presented while busy is set has no effect on the control register or the counter.
- R5: The count register at offset 0x4 is read-only. A write there changes no register and does not start a load phase.
- R6: The tick period is max(1, CYC_PER_SEC >> resolution) cycles. It starts from a fresh phase at the load edge, so with reload N and period P the counter is first decremented at load edge + P.
- R7: When an enabled counter would pass from 1 (or from a loaded 0) to 0 on a tick, timeout_o sets. It stays set, and the counter stays at zero, until the next load completes, which clears it.
- R8: On expiry, rst_req_o is high for exactly one cycle, and only if the reset-on-expiry enable is set.
- R9: With enable clear, the counter holds its value.
- R10: Rewriting the control register with enable set restarts the countdown from the new reload value, so a kick given before expiry postpones the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data |
| timeout_o | output | 1 | Sticky expiry flag |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume every request lasts a single cycle and that the register port has no notion of a stalled transfer. They also assume a write during the load phase is dropped rather than queued, so the checker only relates counter and flag movement to the internal load and tick strobes. The bench drives every request for exactly one cycle, on the falling edge. It deliberately places a second write inside a load phase and a write to the read-only offset. It uses only the documented field positions when it forms and predicts register values.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W    = 20;
  localparam int RES_W    = 4;
  localparam int BUS_W    = 32;
  localparam int BIT_BUSY = 28;
  localparam int BIT_EN   = 27;
  localparam int BIT_SRST = 26;
  localparam int RES_LSB  = 20;
  localparam logic [RES_W-1:0] RES_RESET = 4'd4;

  typedef struct packed {
    logic             en;
    logic             srst_en;
    logic [RES_W-1:0] res;
    logic [CNT_W-1:0] reload;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int LOAD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [CNT_W-1:0]  count_i,
  output ctrl_t             ctrl_o,
  output logic              busy_o,
  output logic              load_o,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_data
);
  localparam int BCNT_W = $clog2(LOAD_CYCLES + 1);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(4);

  logic [BCNT_W-1:0] bcnt_q;
  logic              ctrl_wr;
  logic [BUS_W-1:0]  rd_mux;

  assign ctrl_wr = req_valid && req_write && (req_addr == OFS_CTRL) && !busy_o;
  assign load_o  = busy_o && (bcnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '{en: 1'b0, srst_en: 1'b0, res: RES_RESET, reload: '0};
      busy_o <= 1'b0;
      bcnt_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_o.en      <= req_wdata[BIT_EN];
      ctrl_o.srst_en <= req_wdata[BIT_SRST];
      ctrl_o.res     <= req_wdata[RES_LSB +: RES_W];
      ctrl_o.reload  <= req_wdata[CNT_W-1:0];
      busy_o         <= 1'b1;
      bcnt_q         <= BCNT_W'(LOAD_CYCLES - 1);
    end else if (load_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      bcnt_q <= bcnt_q - 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == OFS_CTRL) begin
      rd_mux[BIT_BUSY]              = busy_o;
      rd_mux[BIT_EN]                = ctrl_o.en;
      rd_mux[BIT_SRST]              = ctrl_o.srst_en;
      rd_mux[RES_LSB +: RES_W]      = ctrl_o.res;
      rd_mux[CNT_W-1:0]             = ctrl_o.reload;
    end else if (req_addr == OFS_COUNT) begin
      rd_mux[CNT_W-1:0]             = count_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_data <= rd_mux;
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int CYC_PER_SEC = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [RES_W-1:0] res_i,
  output logic             tick_o
);
  localparam int NRES = 1 << RES_W;
  localparam int PW   = $clog2(CYC_PER_SEC + 1);

  logic [PW-1:0] per_tab [NRES];
  logic [PW-1:0] period;
  logic [PW-1:0] pcnt_q;

  for (genvar r = 0; r < NRES; r++) begin : g_period
    localparam int SHIFTED = CYC_PER_SEC >> r;
    localparam int PER     = (SHIFTED < 1) ? 1 : SHIFTED;
    assign per_tab[r] = PW'(PER);
  end

  assign period = per_tab[res_i];
  assign tick_o = run_i && (pcnt_q == period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pcnt_q <= '0;
    else if (restart_i || !run_i)   pcnt_q <= '0;
    else if (tick_o)                pcnt_q <= '0;
    else                            pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             en_i,
  input  logic             srst_en_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             timeout_o,
  output logic             rst_req_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o   <= '0;
      timeout_o <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= 1'b0;
      if (load_i) begin
        count_o   <= reload_i;
        timeout_o <= 1'b0;
      end else if (tick_i && en_i && !timeout_o) begin
        if (count_o > CNT_W'(1)) begin
          count_o <= count_o - 1'b1;
        end else begin
          count_o   <= '0;
          timeout_o <= 1'b1;
          rst_req_o <= srst_en_i;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CYC_PER_SEC = 32768,
  parameter int LOAD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              timeout_o,
  output logic              rst_req_o
);
  ctrl_t            ctrl;
  logic             busy;
  logic             load;
  logic             tick;
  logic [CNT_W-1:0] count;

  wdt_regs #(.ADDR_W(ADDR_W), .LOAD_CYCLES(LOAD_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .count_i(count), .ctrl_o(ctrl), .busy_o(busy), .load_o(load),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  wdt_prescaler #(.CYC_PER_SEC(CYC_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .run_i(ctrl.en && !busy), .restart_i(load),
    .res_i(ctrl.res), .tick_o(tick)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .reload_i(ctrl.reload),
    .en_i(ctrl.en), .srst_en_i(ctrl.srst_en), .tick_i(tick),
    .count_o(count), .timeout_o(timeout_o), .rst_req_o(rst_req_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int LOAD_CYCLES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             busy,
  input logic             load,
  input logic             tick,
  input ctrl_t            ctrl,
  input logic [CNT_W-1:0] count,
  input logic             timeout,
  input logic             rst_req
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_run < LOAD_CYCLES);

  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_run == LOAD_CYCLES - 1) |=> !busy);

  p_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && req_write) |=> $stable(ctrl));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !timeout && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1));

  p_timeout_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !load) |=> timeout);

  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_rst_with_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> timeout);

  p_hold_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !load) |=> $stable(count));
endmodule

bind wdt_timer wdt_checker #(.LOAD_CYCLES(LOAD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .busy(busy), .load(load), .tick(tick), .ctrl(ctrl), .count(count),
  .timeout(timeout_o), .rst_req(rst_req_o)
);

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;
  localparam int ADDR_W = 4;
  localparam int CPS    = 64;
  localparam int LOADC  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_data;
  logic              timeout_o;
  logic              rst_req_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wr_edge = 0;
  int rst_cnt = 0;
  int rst_edge = -1;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  wdt_timer #(.ADDR_W(ADDR_W), .CYC_PER_SEC(CPS), .LOAD_CYCLES(LOADC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .timeout_o(timeout_o), .rst_req_o(rst_req_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on each response, and reset-request tracking.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", rsp_data, 0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_data === e, t, rsp_data, e);
      end
    end
    if (rst_n && rst_req_o) begin
      rst_cnt++;
      rst_edge = cyc;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    wr_edge = cyc;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit sr, input int res, input int cnt);
    return (32'(en) << 27) | (32'(sr) << 26) | (32'(res) << 20) | (32'(cnt) & 32'hFFFFF);
  endfunction

  function automatic int per(input int res);
    return ((CPS >> res) < 1) ? 1 : (CPS >> res);
  endfunction

  task automatic finish_run();
    if (exp_q.size() != 0) check(1'b0, "R2 missing responses", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1: reset state
    check(timeout_o == 1'b0, "R1 timeout after reset", timeout_o, 0);
    check(rst_req_o == 1'b0, "R1 rst_req after reset", rst_req_o, 0);
    rd(4'h0, 32'h0040_0000, "R1 ctrl reset value");
    rd(4'h4, 32'h0, "R1 count reset value");
    step(2);

    // R2/R3: all reserved bits and busy bit written; busy for LOADC cycles
    wr(4'h0, 32'hFF40_0005);
    for (int i = 0; i < LOADC; i++) rd(4'h0, 32'h1C40_0005, "R3 busy during load, R2 reserved zero");
    rd(4'h0, 32'h0C40_0005, "R3 busy clear after load");
    rd(4'h4, 32'h5, "R3 count loaded");
    step(40);
    check(rst_edge == wr_edge + LOADC + 5 * per(4), "R6 R8 expiry edge res4", rst_edge, wr_edge + LOADC + 5 * per(4));
    check(rst_cnt == 1, "R8 single reset pulse", rst_cnt, 1);
    check(timeout_o == 1'b1, "R7 timeout sticky", timeout_o, 1);
    rd(4'h4, 32'h0, "R7 count holds zero");
    step(2);

    // R7/R8: reload clears timeout; no reset request when disabled
    wr(4'h0, ctl(1, 0, 6, 3));
    step(LOADC + 3 * per(6) - 1);
    check(timeout_o == 1'b0, "R7 timeout cleared by load", timeout_o, 0);
    step(1);
    check(timeout_o == 1'b1, "R7 expiry without reset enable", timeout_o, 1);
    check(rst_cnt == 1, "R8 no pulse when reset-enable clear", rst_cnt, 1);

    // R10: kick before expiry postpones timeout
    wr(4'h0, ctl(1, 0, 4, 10));
    step(30);
    wr(4'h0, ctl(1, 0, 4, 10));
    step(LOADC + 10 * per(4) - 1);
    check(timeout_o == 1'b0, "R10 kick postpones expiry", timeout_o, 0);
    step(1);
    check(timeout_o == 1'b1, "R10 expiry after kick", timeout_o, 1);

    // R4: write during load phase ignored; R9 disabled counter holds
    wr(4'h0, ctl(0, 0, 4, 'h12345));
    wr(4'h0, ctl(1, 1, 2, 'h00777));
    step(10);
    rd(4'h0, 32'h0041_2345, "R4 second write ignored");
    rd(4'h4, 32'h0001_2345, "R4 count from first write");
    step(20);
    rd(4'h4, 32'h0001_2345, "R9 disabled count holds");
    check(timeout_o == 1'b0, "R7 timeout cleared, R9 no expiry", timeout_o, 0);

    // R5: count register read-only
    wr(4'h4, 32'h0000_0005);
    rd(4'h0, 32'h0041_2345, "R5 no load phase after count write");
    rd(4'h4, 32'h0001_2345, "R5 count unchanged");

    // R2: max count, unmapped offset
    wr(4'h0, ctl(0, 0, 4, 'hFFFFF));
    step(LOADC + 2);
    rd(4'h4, 32'h000F_FFFF, "R2 max count");
    rd(4'h8, 32'h0, "R2 unmapped offset reads zero");
    step(2);

    // R6: resolution 0 (longest tick)
    wr(4'h0, ctl(1, 1, 0, 1));
    step(LOADC + per(0) + 6);
    check(rst_cnt == 2, "R8 pulse at res0", rst_cnt, 2);
    check(rst_edge == wr_edge + LOADC + per(0), "R6 expiry edge res0", rst_edge, wr_edge + LOADC + per(0));

    // R6/R7: resolution 15 clamps to one cycle, zero reload expires on first tick
    wr(4'h0, ctl(1, 1, 15, 0));
    step(LOADC + 6);
    check(rst_cnt == 3, "R7 zero reload expiry pulse", rst_cnt, 3);
    check(rst_edge == wr_edge + LOADC + per(15), "R6 expiry edge res15", rst_edge, wr_edge + LOADC + per(15));

    step(4);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", cyc, 0);
      finish_run();
    end
  end
endmodule